// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps large, contiguous regions of the effective address space onto physical memory without a page walk. It has two independent sides, one for instruction fetches and one for data accesses. Each side holds a parameterised number of translation entries, and each entry is written as two 32-bit words. Each side has its own translation-enable input. With translation off, an access keeps its effective address and receives fixed default storage attributes. With translation on, the upper address bits are compared against every entry of that side at the same time. A match supplies the physical address, the WIMG storage attributes and a protection verdict, all in the same cycle as the request.

Software must clear every valid bit before it enables translation, because the entry registers take no reset. Two valid entries that match the same address are a programming error. The unit does not leave that case undefined: it flags the overlap on a dedicated output and resolves it deterministically, so that a test can detect the error instead of guessing at it.

Top module: `bat_xlate`

## Requirements
- R1: With data translation disabled and a data request present, the data physical address equals the effective address, the data WIMG output is 4'b0011 (bit order W,I,M,G), and the data hit and miss outputs are both 0.
- R2: With instruction translation disabled and an instruction request present, the instruction physical address equals the effective address, the instruction WIMG output is 4'b0001, and hit and miss are both 0.
- R3: An entry matches when, for effective address bits [31:17], every bit position that is clear in the entry's 11-bit length mask (aligned to bit 17) equals the corresponding bit of the entry's start field. Start bits under set mask bits are ignored.
- R4: Only entries whose valid bit for the current privilege level is set can match. The supervisor valid bit applies when the privilege input is 1, and the user valid bit applies when it is 0.
- R5: On a hit, physical address bits [31:17] are the entry's physical block field ORed with the effective address bits selected by the length mask. Bits [16:0] always pass through unchanged.
- R6: With translation on and the request present, hit or miss is asserted in the same cycle, and never both. On a miss, the physical address equals the effective address and WIMG is 0. With no request, hit, miss, violation and multi-hit are all 0.
- R7: On a hit, the protection field decides the violation output. A value of 2'b00 violates for any access. A value of 2'b01 or 2'b11 violates only for a data store. A value of 2'b10 never violates. Instruction fetches violate only for 2'b00.
- R8: On an instruction-side hit, the W and M attribute bits are driven as 0, whatever the entry holds.
- R9: When two or more valid entries of one side match the request, the multi-hit output is 1, whether translation is on or off. The lowest-index matching entry supplies the translation.
- R10: A write stores its data on the rising clock edge into the entry selected by the index, on the side selected by the side input (1 = data). The high word is {start[31:17], 4'b0, mask[12:2], supervisor valid[1], user valid[0]}. The low word is {physical block[31:17], 10'b0, WIMG[6:3], 1'b0, protection[1:0]}. A write to one side never changes lookups on the other side.
- R11: The number of entries per side is a parameter, and every index up to that count minus one is writable and can match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| wr_en | input | 1 | Register write strobe |
| wr_dside | input | 1 | Write target side: 1 data, 0 instruction |
| wr_idx | input | IDX_W | Entry index to write |
| wr_hi | input | 1 | 1 selects the high word, 0 the low word |
| wr_data | input | 32 | Write data |
| ins_xlat_en | input | 1 | Instruction translation enable |
| ins_req | input | 1 | Instruction lookup request |
| ins_priv | input | 1 | Instruction privilege: 1 supervisor |
| ins_ea | input | 32 | Instruction effective address |
| ins_pa | output | 32 | Instruction physical address |
| ins_wimg | output | 4 | Instruction storage attributes |
| ins_hit | output | 1 | Instruction entry hit |
| ins_miss | output | 1 | Instruction lookup miss |
| ins_viol | output | 1 | Instruction protection violation |
| ins_multi | output | 1 | Instruction multiple match |
| dat_xlat_en | input | 1 | Data translation enable |
| dat_req | input | 1 | Data lookup request |
| dat_priv | input | 1 | Data privilege: 1 supervisor |
| dat_store | input | 1 | Data access is a store |
| dat_ea | input | 32 | Data effective address |
| dat_pa | output | 32 | Data physical address |
| dat_wimg | output | 4 | Data storage attributes |
| dat_hit | output | 1 | Data entry hit |
| dat_miss | output | 1 | Data lookup miss |
| dat_viol | output | 1 | Data protection violation |
| dat_multi | output | 1 | Data multiple match |

## Verification
Every output is combinational from the stored entries, so a corrupted entry field appears in the very lookup that selects that entry. A damaged mask or start field turns a hit into a miss, or widens the matched region. A damaged physical field or attribute field produces a wrong address or wrong WIMG value at once. Damaged valid bits appear as a wrong hit/miss answer, or as a false multi-hit flag, on the first request in the affected region, even with translation off.

// File: rtl/bat_pkg.sv
package bat_pkg;
   localparam int EA_W  = 32;
   localparam int OFS_W = 17;
   localparam int UP_W  = EA_W - OFS_W;
   localparam int BL_W  = 11;
   localparam int WD_W  = 32;

   localparam logic [3:0] DFLT_DAT_WIMG = 4'b0011;
   localparam logic [3:0] DFLT_INS_WIMG = 4'b0001;

   typedef struct packed {
      logic [UP_W-1:0] start;
      logic [BL_W-1:0] len_mask;
      logic            sup_v;
      logic            usr_v;
      logic [UP_W-1:0] phys;
      logic [3:0]      wimg;
      logic [1:0]      prot;
   } bat_ent_t;

   typedef struct packed {
      logic [UP_W-1:0] start;
      logic [BL_W-1:0] len_mask;
      logic            sup_v;
      logic            usr_v;
   } bat_hi_t;

   typedef struct packed {
      logic [UP_W-1:0] phys;
      logic [3:0]      wimg;
      logic [1:0]      prot;
   } bat_lo_t;

   function automatic bat_hi_t unpack_hi(input logic [WD_W-1:0] w);
      bat_hi_t h;
      h.start    = w[31:17];
      h.len_mask = w[12:2];
      h.sup_v    = w[1];
      h.usr_v    = w[0];
      return h;
   endfunction

   function automatic bat_lo_t unpack_lo(input logic [WD_W-1:0] w);
      bat_lo_t l;
      l.phys = w[31:17];
      l.wimg = w[6:3];
      l.prot = w[1:0];
      return l;
   endfunction

   function automatic logic [UP_W-1:0] widen_mask(input logic [BL_W-1:0] m);
      return {{(UP_W-BL_W){1'b0}}, m};
   endfunction
endpackage

// File: rtl/bat_entry_bank.sv
module bat_entry_bank
   import bat_pkg::*;
#(
   parameter int N_ENT = 4,
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic                   wr_hi,
   input  logic [WD_W-1:0]        wr_data,
   output bat_ent_t [N_ENT-1:0]   ents
);
   bat_hi_t hi_word;
   bat_lo_t lo_word;

   always_comb begin
      hi_word = unpack_hi(wr_data);
      lo_word = unpack_lo(wr_data);
   end

   // Entry storage deliberately has no reset: software clears valid bits.
   for (genvar k = 0; k < N_ENT; k++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(k));

      always_ff @(posedge clk) begin
         if (sel && wr_hi) begin
            ents[k].start    <= hi_word.start;
            ents[k].len_mask <= hi_word.len_mask;
            ents[k].sup_v    <= hi_word.sup_v;
            ents[k].usr_v    <= hi_word.usr_v;
         end
         if (sel && !wr_hi) begin
            ents[k].phys <= lo_word.phys;
            ents[k].wimg <= lo_word.wimg;
            ents[k].prot <= lo_word.prot;
         end
      end
   end
endmodule

// File: rtl/bat_lookup.sv
module bat_lookup
   import bat_pkg::*;
#(
   parameter int N_ENT = 4,
   localparam int CNT_W = $clog2(N_ENT + 1)
) (
   input  logic                 clk,
   input  logic                 req,
   input  bat_ent_t [N_ENT-1:0] ents,
   input  logic [UP_W-1:0]      ea_up,
   input  logic                 priv,
   output logic                 any_hit,
   output logic                 multi,
   output bat_ent_t             sel_ent,
   output logic [UP_W-1:0]      xl_up
);
   logic [N_ENT-1:0] match;
   logic [CNT_W-1:0] n_match;

   for (genvar k = 0; k < N_ENT; k++) begin : g_cmp
      logic [UP_W-1:0] keep;
      logic            live;
      assign keep     = ~widen_mask(ents[k].len_mask);
      assign live     = priv ? ents[k].sup_v : ents[k].usr_v;
      assign match[k] = live && ((ea_up & keep) == (ents[k].start & keep));
   end

   // Lowest index wins; the population count drives the overlap flag.
   always_comb begin
      sel_ent = '0;
      any_hit = 1'b0;
      n_match = '0;
      for (int k = N_ENT - 1; k >= 0; k--) begin
         if (match[k]) begin
            sel_ent = ents[k];
            any_hit = 1'b1;
         end
      end
      for (int k = 0; k < N_ENT; k++) begin
         n_match = n_match + CNT_W'(match[k]);
      end
   end

   assign multi = (n_match > CNT_W'(1));
   assign xl_up = sel_ent.phys | (ea_up & widen_mask(sel_ent.len_mask));

   always @(posedge clk) begin
      if (req && any_hit) begin
         a_r3_sel_matches: assert (((ea_up ^ sel_ent.start) & ~widen_mask(sel_ent.len_mask)) == '0)
            else $error("selected entry does not cover the address");
         a_r4_sel_valid: assert (priv ? sel_ent.sup_v : sel_ent.usr_v)
            else $error("selected entry not valid for privilege");
      end
      if (req && multi) begin
         a_r9_multi_has_hit: assert (any_hit)
            else $error("multi-hit without any hit");
      end
   end
endmodule

// File: rtl/bat_side.sv
module bat_side
   import bat_pkg::*;
#(
   parameter int N_ENT   = 4,
   parameter bit IS_DATA = 1'b1,
   localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_hi,
   input  logic [WD_W-1:0]  wr_data,
   input  logic             xlat_en,
   input  logic             req,
   input  logic             priv,
   input  logic             store,
   input  logic [EA_W-1:0]  ea,
   output logic [EA_W-1:0]  pa,
   output logic [3:0]       wimg,
   output logic             hit,
   output logic             miss,
   output logic             viol,
   output logic             multi
);
   bat_ent_t [N_ENT-1:0] ents;
   bat_ent_t             sel_ent;
   logic                 any_hit;
   logic                 multi_raw;
   logic [UP_W-1:0]      xl_up;
   logic [3:0]           dflt_wimg;
   logic [3:0]           hit_wimg;
   logic                 prot_bad;

   bat_entry_bank #(.N_ENT(N_ENT)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .ents    (ents)
   );

   bat_lookup #(.N_ENT(N_ENT)) u_look (
      .clk     (clk),
      .req     (req),
      .ents    (ents),
      .ea_up   (ea[EA_W-1:OFS_W]),
      .priv    (priv),
      .any_hit (any_hit),
      .multi   (multi_raw),
      .sel_ent (sel_ent),
      .xl_up   (xl_up)
   );

   if (IS_DATA) begin : g_dat
      assign dflt_wimg = DFLT_DAT_WIMG;
      assign hit_wimg  = sel_ent.wimg;
   end else begin : g_ins
      // W and M carry no meaning for fetches.
      assign dflt_wimg = DFLT_INS_WIMG;
      assign hit_wimg  = {1'b0, sel_ent.wimg[2], 1'b0, sel_ent.wimg[0]};
   end

   assign prot_bad = (sel_ent.prot == 2'b00) || (IS_DATA && store && sel_ent.prot[0]);

   always_comb begin
      pa    = ea;
      wimg  = dflt_wimg;
      hit   = 1'b0;
      miss  = 1'b0;
      viol  = 1'b0;
      if (xlat_en) begin
         wimg = '0;
         if (any_hit) begin
            pa   = {xl_up, ea[OFS_W-1:0]};
            wimg = hit_wimg;
         end
         hit  = req && any_hit;
         miss = req && !any_hit;
         viol = req && any_hit && prot_bad;
      end
      multi = req && multi_raw;
   end

   always @(posedge clk) begin
      if (req && !xlat_en) begin
         a_r1_r2_real_mode: assert (pa == ea && wimg == dflt_wimg && !hit && !miss)
            else $error("real-mode output wrong");
      end
      if (req) begin
         a_r5_low_pass: assert (pa[OFS_W-1:0] == ea[OFS_W-1:0])
            else $error("low offset bits altered");
         a_r6_hit_miss_excl: assert (!(hit && miss))
            else $error("hit and miss together");
      end
      if (viol) begin
         a_r7_viol_needs_hit: assert (hit)
            else $error("violation without hit");
      end
      if (hit && !IS_DATA) begin
         a_r8_ins_wm_zero: assert (wimg[3] == 1'b0 && wimg[1] == 1'b0)
            else $error("fetch W/M not cleared");
      end
   end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
   import bat_pkg::*;
#(
   parameter int N_ENT = 4,
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic             wr_dside,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_hi,
   input  logic [31:0]      wr_data,
   input  logic             ins_xlat_en,
   input  logic             ins_req,
   input  logic             ins_priv,
   input  logic [31:0]      ins_ea,
   output logic [31:0]      ins_pa,
   output logic [3:0]       ins_wimg,
   output logic             ins_hit,
   output logic             ins_miss,
   output logic             ins_viol,
   output logic             ins_multi,
   input  logic             dat_xlat_en,
   input  logic             dat_req,
   input  logic             dat_priv,
   input  logic             dat_store,
   input  logic [31:0]      dat_ea,
   output logic [31:0]      dat_pa,
   output logic [3:0]       dat_wimg,
   output logic             dat_hit,
   output logic             dat_miss,
   output logic             dat_viol,
   output logic             dat_multi
);
   if (N_ENT < 1 || N_ENT > 16) begin : g_bad_n
      $error("N_ENT must lie in 1..16");
   end
   if (UP_W + OFS_W != EA_W || BL_W > UP_W) begin : g_bad_w
      $error("address field widths inconsistent");
   end

   // R11: both sides sized by the same parameter.
   bat_side #(.N_ENT(N_ENT), .IS_DATA(1'b0)) u_ins (
      .clk     (clk),
      .wr_en   (wr_en && !wr_dside),
      .wr_idx  (wr_idx),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .xlat_en (ins_xlat_en),
      .req     (ins_req),
      .priv    (ins_priv),
      .store   (1'b0),
      .ea      (ins_ea),
      .pa      (ins_pa),
      .wimg    (ins_wimg),
      .hit     (ins_hit),
      .miss    (ins_miss),
      .viol    (ins_viol),
      .multi   (ins_multi)
   );

   bat_side #(.N_ENT(N_ENT), .IS_DATA(1'b1)) u_dat (
      .clk     (clk),
      .wr_en   (wr_en && wr_dside),
      .wr_idx  (wr_idx),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .xlat_en (dat_xlat_en),
      .req     (dat_req),
      .priv    (dat_priv),
      .store   (dat_store),
      .ea      (dat_ea),
      .pa      (dat_pa),
      .wimg    (dat_wimg),
      .hit     (dat_hit),
      .miss    (dat_miss),
      .viol    (dat_viol),
      .multi   (dat_multi)
   );
endmodule

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        wr_en = 0, wr_dside = 0, wr_hi = 0;
   logic [1:0]  wr_idx = 0;
   logic [31:0] wr_data = 0;
   logic        ins_xlat_en = 0, ins_req = 0, ins_priv = 0;
   logic [31:0] ins_ea = 0, ins_pa;
   logic [3:0]  ins_wimg;
   logic        ins_hit, ins_miss, ins_viol, ins_multi;
   logic        dat_xlat_en = 0, dat_req = 0, dat_priv = 0, dat_store = 0;
   logic [31:0] dat_ea = 0, dat_pa;
   logic [3:0]  dat_wimg;
   logic        dat_hit, dat_miss, dat_viol, dat_multi;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bat_xlate #(.N_ENT(N)) u_dut (.*);

   typedef struct packed {
      logic ds; logic xen; logic priv; logic st;
      logic [31:0] ea; logic [31:0] pa; logic [3:0] wimg;
      logic hit; logic miss; logic viol; logic multi;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b1,1'b0,32'h1234_5678,32'h1234_5678,4'b0011,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b0,32'h0010_0004,32'h0010_0004,4'b0001,1'b0,1'b0,1'b0,1'b0},
      '{1'b1,1'b1,1'b1,1'b0,32'h1001_2345,32'h2001_2345,4'b0101,1'b1,1'b0,1'b0,1'b0},
      '{1'b1,1'b1,1'b1,1'b0,32'h1002_0000,32'h1002_0000,4'b0000,1'b0,1'b1,1'b0,1'b0},
      '{1'b1,1'b1,1'b1,1'b0,32'h400F_FFFC,32'h008F_FFFC,4'b0010,1'b1,1'b0,1'b0,1'b0},
      '{1'b1,1'b1,1'b1,1'b1,32'h400F_FFFC,32'h008F_FFFC,4'b0010,1'b1,1'b0,1'b1,1'b0},
      '{1'b1,1'b1,1'b0,1'b0,32'h400F_FFFC,32'h400F_FFFC,4'b0000,1'b0,1'b1,1'b0,1'b0},
      '{1'b1,1'b1,1'b0,1'b0,32'h8000_0010,32'h0000_0010,4'b1000,1'b1,1'b0,1'b1,1'b0},
      '{1'b1,1'b1,1'b1,1'b0,32'h8000_0010,32'h8000_0010,4'b0000,1'b0,1'b1,1'b0,1'b0},
      '{1'b1,1'b1,1'b1,1'b1,32'h1000_0000,32'h2000_0000,4'b0101,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b1,1'b1,1'b0,32'h0011_0000,32'h0301_0000,4'b0100,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b1,1'b0,1'b0,32'h0020_0040,32'h0040_0040,4'b0000,1'b1,1'b0,1'b1,1'b0},
      '{1'b0,1'b1,1'b1,1'b0,32'h1000_0000,32'h1000_0000,4'b0000,1'b0,1'b1,1'b0,1'b0},
      '{1'b0,1'b1,1'b1,1'b0,32'h0030_0000,32'h0030_0000,4'b0000,1'b0,1'b1,1'b0,1'b0}
   };
   localparam string VTAG [NV] = '{"R1","R2","R5","R3","R5","R7","R4","R7",
                                   "R4","R7","R8","R7","R10","R3"};

   function automatic logic [31:0] hi_w(input logic [14:0] s, input logic [10:0] m,
                                        input logic sv, input logic uv);
      return {s, 4'b0, m, sv, uv};
   endfunction

   function automatic logic [31:0] lo_w(input logic [14:0] p, input logic [3:0] w,
                                        input logic [1:0] pp);
      return {p, 10'b0, w, 1'b0, pp};
   endfunction

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic wr(input logic ds, input int idx, input logic hi, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_dside = ds; wr_idx = 2'(idx); wr_hi = hi; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic look(input vec_t v);
      @(negedge clk);
      ins_req = 0; dat_req = 0;
      if (v.ds) begin
         dat_req = 1; dat_xlat_en = v.xen; dat_priv = v.priv; dat_store = v.st; dat_ea = v.ea;
      end else begin
         ins_req = 1; ins_xlat_en = v.xen; ins_priv = v.priv; ins_ea = v.ea;
      end
      #1;
   endtask

   task automatic chk_dat(input string rq, input vec_t v);
      chk(rq, "dat_pa", dat_pa, v.pa);
      chk(rq, "dat_wimg", {28'b0, dat_wimg}, {28'b0, v.wimg});
      chk(rq, "dat flags", {28'b0, dat_hit, dat_miss, dat_viol, dat_multi},
          {28'b0, v.hit, v.miss, v.viol, v.multi});
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      // Software duty: clear every valid bit before use.
      for (int k = 0; k < N; k++) begin
         wr(1'b0, k, 1'b1, 32'h0);
         wr(1'b1, k, 1'b1, 32'h0);
      end
      // Idle outputs (R6)
      #1;
      chk("R6", "idle ins flags", {28'b0, ins_hit, ins_miss, ins_viol, ins_multi}, 32'h0);
      chk("R6", "idle dat flags", {28'b0, dat_hit, dat_miss, dat_viol, dat_multi}, 32'h0);

      // Data entries (R10 layout)
      wr(1'b1, 0, 1'b1, hi_w(15'h0800, 11'h000, 1'b1, 1'b1));
      wr(1'b1, 0, 1'b0, lo_w(15'h1000, 4'b0101, 2'b10));
      wr(1'b1, 1, 1'b1, hi_w(15'h2000, 11'h007, 1'b1, 1'b0));
      wr(1'b1, 1, 1'b0, lo_w(15'h0040, 4'b0010, 2'b01));
      wr(1'b1, 2, 1'b1, hi_w(15'h4000, 11'h000, 1'b0, 1'b1));
      wr(1'b1, 2, 1'b0, lo_w(15'h0000, 4'b1000, 2'b00));
      // Instruction entries
      wr(1'b0, 0, 1'b1, hi_w(15'h0008, 11'h000, 1'b1, 1'b1));
      wr(1'b0, 0, 1'b0, lo_w(15'h0180, 4'b1110, 2'b11));
      wr(1'b0, 1, 1'b1, hi_w(15'h0010, 11'h000, 1'b1, 1'b1));
      wr(1'b0, 1, 1'b0, lo_w(15'h0020, 4'b0000, 2'b00));

      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         look(v);
         if (v.ds) chk_dat(VTAG[i], v);
         else begin
            chk(VTAG[i], "ins_pa", ins_pa, v.pa);
            chk(VTAG[i], "ins_wimg", {28'b0, ins_wimg}, {28'b0, v.wimg});
            chk(VTAG[i], "ins flags", {28'b0, ins_hit, ins_miss, ins_viol, ins_multi},
                {28'b0, v.hit, v.miss, v.viol, v.multi});
         end
      end

      // R9 / R11: overlap at top index; lowest index wins
      wr(1'b1, 3, 1'b1, hi_w(15'h0800, 11'h000, 1'b1, 1'b1));
      wr(1'b1, 3, 1'b0, lo_w(15'h3000, 4'b0000, 2'b10));
      v = '{1'b1,1'b1,1'b1,1'b0,32'h1000_0100,32'h2000_0100,4'b0101,1'b1,1'b0,1'b0,1'b1};
      look(v); chk_dat("R9", v);
      v = '{1'b1,1'b0,1'b1,1'b0,32'h1000_0100,32'h1000_0100,4'b0011,1'b0,1'b0,1'b0,1'b1};
      look(v); chk_dat("R9", v);

      // R3 / R11: start bits under the mask ignored, top index matches
      wr(1'b1, 3, 1'b1, hi_w(15'h3005, 11'h007, 1'b1, 1'b1));
      wr(1'b1, 3, 1'b0, lo_w(15'h0010, 4'b0100, 2'b10));
      v = '{1'b1,1'b1,1'b1,1'b0,32'h6000_0000,32'h0020_0000,4'b0100,1'b1,1'b0,1'b0,1'b0};
      look(v); chk_dat("R11", v);
      v = '{1'b1,1'b1,1'b1,1'b0,32'h1000_0100,32'h2000_0100,4'b0101,1'b1,1'b0,1'b0,1'b0};
      look(v); chk_dat("R9", v);

      // R10: data-side writes left the instruction side intact
      v = '{1'b0,1'b1,1'b1,1'b0,32'h0011_0000,32'h0301_0000,4'b0100,1'b1,1'b0,1'b0,1'b0};
      look(v);
      chk("R10", "ins_pa after data writes", ins_pa, v.pa);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule